// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block collects peripheral interrupt lines arranged in groups, each group holding a fixed number of level-sensitive lines. Every group is assigned one of four priority levels and an autovector through a per-group priority register. For each level the block works out which group is pending, favouring the lowest group number on a tie. It then offers the CPU a single request carrying the highest pending level and the autovector of the group chosen at that level.

A separate non-maskable input produces its own output and suppresses the regular request while it is active. A small register port lets software do three things. It can write and read the priority registers. It can read the sampled line state of each group. It can read the per-level cause registers.

Register addressing uses `reg_addr_i[7:6]` as the space and `reg_addr_i[5:0]` as the index. Space 0 holds the priority registers: bits [31:30] are the level and bits [AV_W-1:0] are the autovector. Space 1 holds the request registers, with line k of the group in bit k. Space 2 holds the cause registers, indexed by level: bit 31 is the valid bit and the low bits are the group number. Space 3 reads as zero.

Top module: `grp_irq_ctrl`

## Requirements
- R1: Reading space 1 at index g returns, one cycle after the lines were applied, the lines of group g as sampled at that clock edge. Line k is in bit k.
- R2: For each level L, the cause register (space 2, index L) reports the lowest-numbered group that has any line high and whose priority level is L, with bit 31 set. Bits [4:0] carry the group number.
- R3: When no group is pending at level L, the cause register for that level reads exactly zero, which also clears its valid bit.
- R4: Outside NMI, `irq_req_o` is high when any level is pending. `irq_lvl_o` then gives the highest pending level, where 3 ranks highest. `irq_av_o` gives the autovector of the group named in that level's cause register.
- R5: `nmi_o` follows `nmi_i` with one cycle of delay. While it is high, `irq_req_o`, `irq_lvl_o` and `irq_av_o` are all zero.
- R6: After reset every priority register reads zero, every cause register reads zero and all outputs are low.
- R7: A write to space 0 at index g loads level = wdata[31:30] and autovector = wdata[AV_W-1:0]. Arbitration at the edge of the write still uses the old value; the new value takes effect from the next edge on.
- R8: Writes to spaces 1, 2 and 3 change no state. Priority register bits outside the level and autovector fields read zero.
- R9: All cause and CPU-side outputs reflect the inputs sampled at the previous clock edge. With nothing pending, all CPU-side outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | N_GROUPS*LINES | Request lines; group g occupies bits [g*LINES +: LINES] |
| nmi_i | input | 1 | Non-maskable request |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Space [7:6] and index [5:0] |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from register state |
| irq_req_o | output | 1 | Regular interrupt request to the CPU |
| irq_lvl_o | output | 2 | Level of the presented request |
| irq_av_o | output | AV_W | Autovector of the presented request |
| nmi_o | output | 1 | Non-maskable request to the CPU |

## Verification
Every result here appears one edge after its stimulus. This covers the request registers, the cause registers, the CPU request, level, autovector and NMI output. The bench drives lines, NMI and writes at the falling edge. It computes the expected values from its own priority model as it stood before that edge's write, then compares the outputs at the following falling edge. Register reads are combinational, so the bench performs them in that same low phase, a fraction of a nanosecond apart, before the next stimulus. This lets the bench observe a write's one-edge delay directly: the cycle carrying the write is still judged against the old priority.

// File: rtl/gic_pkg.sv
package gic_pkg;
  localparam int unsigned NUM_LVL = 4;
  localparam int unsigned LVL_W   = 2;
  localparam int unsigned IDX_W   = 6;

  typedef logic [LVL_W-1:0] lvl_t;

  typedef enum logic [1:0] {
    SPC_PRIO  = 2'd0,
    SPC_REQ   = 2'd1,
    SPC_CAUSE = 2'd2,
    SPC_NONE  = 2'd3
  } space_e;
endpackage

// File: rtl/gic_prio_file.sv
module gic_prio_file
  import gic_pkg::*;
#(
  parameter int unsigned N_GROUPS = 19,
  parameter int unsigned AV_W     = 14
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_i,
  input  logic [IDX_W-1:0]               idx_i,
  input  logic [31:0]                    wdata_i,
  output lvl_t [N_GROUPS-1:0]            lvl_o,
  output logic [N_GROUPS-1:0][AV_W-1:0]  av_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_o <= '0;
      av_o  <= '0;
    end else if (wr_i) begin
      for (int g = 0; g < int'(N_GROUPS); g++) begin
        if (idx_i == IDX_W'(g)) begin
          lvl_o[g] <= wdata_i[31:30];
          av_o[g]  <= wdata_i[AV_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/gic_lvl_arb.sv
module gic_lvl_arb
  import gic_pkg::*;
#(
  parameter int unsigned N_GROUPS = 19,
  parameter int unsigned GRP_W    = 5,
  parameter int unsigned LVL      = 0
) (
  input  logic [N_GROUPS-1:0] pend_i,
  input  lvl_t [N_GROUPS-1:0] lvl_i,
  output logic                vld_o,
  output logic [GRP_W-1:0]    grp_o
);
  // descending scan: last hit is the lowest group number
  always_comb begin
    vld_o = 1'b0;
    grp_o = '0;
    for (int g = int'(N_GROUPS) - 1; g >= 0; g--) begin
      if (pend_i[g] && lvl_i[g] == LVL_W'(LVL)) begin
        vld_o = 1'b1;
        grp_o = GRP_W'(g);
      end
    end
  end
endmodule

// File: rtl/gic_out_sel.sv
module gic_out_sel
  import gic_pkg::*;
#(
  parameter int unsigned N_GROUPS = 19,
  parameter int unsigned GRP_W    = 5,
  parameter int unsigned AV_W     = 14
) (
  input  logic                           nmi_i,
  input  logic [NUM_LVL-1:0]             vld_i,
  input  logic [NUM_LVL-1:0][GRP_W-1:0]  grp_i,
  input  logic [N_GROUPS-1:0][AV_W-1:0]  av_i,
  output logic                           req_o,
  output lvl_t                           lvl_o,
  output logic [AV_W-1:0]                av_o
);
  // ascending scan: highest pending level wins
  always_comb begin
    req_o = 1'b0;
    lvl_o = '0;
    av_o  = '0;
    if (!nmi_i) begin
      for (int l = 0; l < int'(NUM_LVL); l++) begin
        if (vld_i[l]) begin
          req_o = 1'b1;
          lvl_o = LVL_W'(l);
          av_o  = av_i[grp_i[l]];
        end
      end
    end
  end
endmodule

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl
  import gic_pkg::*;
#(
  parameter int unsigned N_GROUPS = 19,
  parameter int unsigned LINES    = 32,
  parameter int unsigned AV_W     = 14
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_GROUPS*LINES-1:0] irq_i,
  input  logic                      nmi_i,
  input  logic                      reg_we_i,
  input  logic [7:0]                reg_addr_i,
  input  logic [31:0]               reg_wdata_i,
  output logic [31:0]               reg_rdata_o,
  output logic                      irq_req_o,
  output logic [LVL_W-1:0]          irq_lvl_o,
  output logic [AV_W-1:0]           irq_av_o,
  output logic                      nmi_o
);
  localparam int unsigned GRP_W = (N_GROUPS > 1) ? $clog2(N_GROUPS) : 1;

  space_e                          spc;
  logic [IDX_W-1:0]                idx;
  logic                            prio_wr;
  logic [N_GROUPS-1:0][LINES-1:0]  req_q;
  logic [N_GROUPS-1:0]             pend;
  lvl_t [N_GROUPS-1:0]             prio_lvl;
  logic [N_GROUPS-1:0][AV_W-1:0]   prio_av;
  logic [NUM_LVL-1:0]              cause_vld_d, cause_vld_q;
  logic [NUM_LVL-1:0][GRP_W-1:0]   cause_grp_d, cause_grp_q;
  logic                            req_d;
  lvl_t                            lvl_d;
  logic [AV_W-1:0]                 av_d;

  assign spc     = space_e'(reg_addr_i[7:6]);
  assign idx     = reg_addr_i[IDX_W-1:0];
  assign prio_wr = reg_we_i && (spc == SPC_PRIO);

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_pend
    assign pend[g] = |irq_i[g*LINES +: LINES];
  end

  gic_prio_file #(.N_GROUPS(N_GROUPS), .AV_W(AV_W)) u_prio (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (prio_wr),
    .idx_i   (idx),
    .wdata_i (reg_wdata_i),
    .lvl_o   (prio_lvl),
    .av_o    (prio_av)
  );

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_arb
    gic_lvl_arb #(.N_GROUPS(N_GROUPS), .GRP_W(GRP_W), .LVL(l)) u_arb (
      .pend_i (pend),
      .lvl_i  (prio_lvl),
      .vld_o  (cause_vld_d[l]),
      .grp_o  (cause_grp_d[l])
    );
  end

  gic_out_sel #(.N_GROUPS(N_GROUPS), .GRP_W(GRP_W), .AV_W(AV_W)) u_sel (
    .nmi_i (nmi_i),
    .vld_i (cause_vld_d),
    .grp_i (cause_grp_d),
    .av_i  (prio_av),
    .req_o (req_d),
    .lvl_o (lvl_d),
    .av_o  (av_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q       <= '0;
      cause_vld_q <= '0;
      cause_grp_q <= '0;
      irq_req_o   <= 1'b0;
      irq_lvl_o   <= '0;
      irq_av_o    <= '0;
      nmi_o       <= 1'b0;
    end else begin
      req_q       <= irq_i;
      cause_vld_q <= cause_vld_d;
      cause_grp_q <= cause_grp_d;
      irq_req_o   <= req_d;
      irq_lvl_o   <= lvl_d;
      irq_av_o    <= av_d;
      nmi_o       <= nmi_i;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (spc)
      SPC_PRIO: begin
        for (int g = 0; g < int'(N_GROUPS); g++) begin
          if (idx == IDX_W'(g)) begin
            reg_rdata_o[31:30]     = prio_lvl[g];
            reg_rdata_o[AV_W-1:0]  = prio_av[g];
          end
        end
      end
      SPC_REQ: begin
        for (int g = 0; g < int'(N_GROUPS); g++) begin
          if (idx == IDX_W'(g)) reg_rdata_o[LINES-1:0] = req_q[g];
        end
      end
      SPC_CAUSE: begin
        for (int l = 0; l < int'(NUM_LVL); l++) begin
          if (idx == IDX_W'(l)) begin
            reg_rdata_o[31]        = cause_vld_q[l];
            reg_rdata_o[GRP_W-1:0] = cause_grp_q[l];
          end
        end
      end
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/grp_irq_ctrl_chk.sv
module grp_irq_ctrl_chk
  import gic_pkg::*;
#(
  parameter int unsigned N_GROUPS = 19,
  parameter int unsigned LINES    = 32,
  parameter int unsigned AV_W     = 14,
  parameter int unsigned GRP_W    = 5
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          irq_req_o,
  input logic [LVL_W-1:0]              irq_lvl_o,
  input logic [AV_W-1:0]               irq_av_o,
  input logic                          nmi_o,
  input logic [NUM_LVL-1:0]            cause_vld_q,
  input logic [NUM_LVL-1:0][GRP_W-1:0] cause_grp_q,
  input logic [N_GROUPS-1:0][LINES-1:0] req_q
);
  a_r5_nmi_blocks_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o |-> !irq_req_o);

  a_r4_req_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> cause_vld_q[irq_lvl_o]);

  a_r9_idle_outputs_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_req_o |-> (irq_lvl_o == '0 && irq_av_o == '0));

  a_r4_pending_raises_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nmi_o && |cause_vld_q) |-> irq_req_o);

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    a_r3_idle_cause_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cause_vld_q[l] |-> cause_grp_q[l] == '0);

    a_r2_cause_is_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cause_vld_q[l] |-> (cause_grp_q[l] < GRP_W'(N_GROUPS) && |req_q[cause_grp_q[l]]));

    a_r4_highest_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_req_o && cause_vld_q[l]) |-> irq_lvl_o >= LVL_W'(l));
  end
endmodule

bind grp_irq_ctrl grp_irq_ctrl_chk #(
  .N_GROUPS (N_GROUPS),
  .LINES    (LINES),
  .AV_W     (AV_W),
  .GRP_W    (GRP_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .irq_req_o   (irq_req_o),
  .irq_lvl_o   (irq_lvl_o),
  .irq_av_o    (irq_av_o),
  .nmi_o       (nmi_o),
  .cause_vld_q (cause_vld_q),
  .cause_grp_q (cause_grp_q),
  .req_q       (req_q)
);

// File: tb/grp_irq_ctrl_test.sv
`timescale 1ns/100ps
module grp_irq_ctrl_test;
  localparam int NG = 19;
  localparam int NL = 32;
  localparam int AW = 14;
  localparam int NI = NG * NL;
  localparam logic [31:0] AV_MASK = (32'd1 << AW) - 32'd1;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NI-1:0] irq_i = '0;
  logic          nmi_i = 1'b0;
  logic          reg_we_i = 1'b0;
  logic [7:0]    reg_addr_i = '0;
  logic [31:0]   reg_wdata_i = '0;
  logic [31:0]   reg_rdata_o;
  logic          irq_req_o;
  logic [1:0]    irq_lvl_o;
  logic [AW-1:0] irq_av_o;
  logic          nmi_o;

  always #5 clk = ~clk;

  grp_irq_ctrl #(.N_GROUPS(NG), .LINES(NL), .AV_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .irq_i(irq_i), .nmi_i(nmi_i),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_req_o(irq_req_o), .irq_lvl_o(irq_lvl_o),
    .irq_av_o(irq_av_o), .nmi_o(nmi_o)
  );

  int unsigned n_vec = 0;
  int unsigned n_fail = 0;
  bit          done = 1'b0;

  int unsigned m_lvl [NG];
  logic [31:0] m_av  [NG];
  logic        e_vld [4];
  int unsigned e_grp [4];
  logic        e_req;
  int unsigned e_lvl;
  logic [31:0] e_av;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic void calc(input logic [NI-1:0] v, input logic n);
    for (int l = 0; l < 4; l++) begin
      e_vld[l] = 1'b0;
      e_grp[l] = 0;
      for (int g = NG - 1; g >= 0; g--)
        if (|v[g*NL +: NL] && m_lvl[g] == l) begin
          e_vld[l] = 1'b1;
          e_grp[l] = g;
        end
    end
    e_req = 1'b0; e_lvl = 0; e_av = '0;
    if (!n)
      for (int l = 0; l < 4; l++)
        if (e_vld[l]) begin
          e_req = 1'b1; e_lvl = l; e_av = m_av[e_grp[l]];
        end
  endfunction

  function automatic logic [31:0] prio_word(input int g);
    return (32'(m_lvl[g]) << 30) | m_av[g];
  endfunction

  // drive at falling edge, judge at the next falling edge
  task automatic step(input logic [NI-1:0] v, input logic n, input logic we,
                      input logic [7:0] a, input logic [31:0] wd, input int rg);
    irq_i = v; nmi_i = n; reg_we_i = we; reg_addr_i = a; reg_wdata_i = wd;
    calc(v, n);
    if (we && a[7:6] == 2'd0 && int'(a[5:0]) < NG) begin
      m_lvl[a[5:0]] = int'(wd[31:30]);
      m_av[a[5:0]]  = wd & AV_MASK;
    end
    @(posedge clk); @(negedge clk);
    reg_we_i = 1'b0;
    chk("R5 nmi_o", 32'(nmi_o), 32'(n));
    chk("R4 irq_req_o", 32'(irq_req_o), 32'(e_req));
    chk("R4 irq_lvl_o", 32'(irq_lvl_o), e_lvl);
    chk("R4 irq_av_o", 32'(irq_av_o), e_av);
    for (int l = 0; l < 4; l++) begin
      reg_addr_i = {2'd2, 6'(l)}; #0.2;
      chk(e_vld[l] ? "R2 cause" : "R3 cause idle", reg_rdata_o,
          (32'(e_vld[l]) << 31) | e_grp[l]);
    end
    reg_addr_i = {2'd1, 6'(rg)}; #0.2;
    chk("R1 request reg", reg_rdata_o, v[rg*NL +: NL]);
    reg_addr_i = {2'd0, 6'(rg)}; #0.2;
    chk("R7 prio readback", reg_rdata_o, prio_word(rg));
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

  initial begin
    logic [NI-1:0] v;
    void'($urandom(32'h1C0FFEE));
    for (int g = 0; g < NG; g++) begin m_lvl[g] = 0; m_av[g] = '0; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R6 reset state
    chk("R6 irq_req_o", 32'(irq_req_o), 0);
    chk("R6 nmi_o", 32'(nmi_o), 0);
    chk("R6 irq_av_o", 32'(irq_av_o), 0);
    for (int g = 0; g < NG; g += 6) begin
      reg_addr_i = {2'd0, 6'(g)}; #0.2;
      chk("R6 prio reset", reg_rdata_o, 0);
    end
    reg_addr_i = {2'd2, 6'd3}; #0.2;
    chk("R6 cause reset", reg_rdata_o, 0);

    // R9 idle
    step('0, 1'b0, 1'b0, 8'h00, 32'h0, 0);
    // R7 write in same cycle as request: old priority still used
    v = '0; v[3*NL] = 1'b1;
    step(v, 1'b0, 1'b1, {2'd0, 6'd3}, 32'h8000_0123, 3);
    v[7*NL + 5] = 1'b1;
    step(v, 1'b0, 1'b1, {2'd0, 6'd7}, 32'h8000_02AA, 7);
    // R2 tie at level 2: group 3 beats group 7
    step(v, 1'b0, 1'b0, 8'h00, 32'h0, 7);
    v[12*NL + 31] = 1'b1;
    step(v, 1'b0, 1'b1, {2'd0, 6'd12}, 32'hC000_0042, 12);
    step(v, 1'b0, 1'b0, 8'h00, 32'h0, 12);
    // R5 nmi suppresses regular request
    step(v, 1'b1, 1'b0, 8'h00, 32'h0, 3);
    step(v, 1'b0, 1'b0, 8'h00, 32'h0, 3);
    // R8 writes to request, cause and unused spaces change nothing
    step(v, 1'b0, 1'b1, {2'd1, 6'd3}, 32'hFFFF_FFFF, 3);
    step(v, 1'b0, 1'b1, {2'd2, 6'd2}, 32'hFFFF_FFFF, 7);
    step(v, 1'b0, 1'b1, {2'd3, 6'd7}, 32'hFFFF_FFFF, 7);
    // R8 unused prio bits read zero
    step(v, 1'b0, 1'b1, {2'd0, 6'd5}, 32'hFFFF_FFFF, 5);
    step('0, 1'b0, 1'b0, 8'h00, 32'h0, 5);
    chk("R8 prio unused bits", reg_rdata_o, 32'hC000_0000 | AV_MASK);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic        we, n;
      logic [7:0]  a;
      logic [31:0] wd;
      v = '0;
      for (int g = 0; g < NG; g++)
        if ($urandom_range(0, 5) == 0) v[g*NL +: NL] = $urandom & $urandom;
      n  = ($urandom_range(0, 9) == 0);
      we = ($urandom_range(0, 7) == 0);
      a  = {($urandom_range(0, 5) == 0) ? 2'($urandom) : 2'd0, 6'($urandom_range(0, NG))};
      wd = $urandom;
      step(v, n, we, a, wd, $urandom_range(0, NG - 1));
    end

    done = 1'b1;
    report();
    $finish;
  end
endmodule